// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block chooses the two operands that the execute stage of a five-stage in-order pipeline feeds to its ALU. Each operand starts as the value read from the register file and held in the decode/execute register. It is then replaced by a newer result when a later instruction has not yet written that register. One newer source is the ALU result held in the execute/memory register, from the instruction now in MEM. The other is the final write value of the instruction now in WB, which may have come from the ALU or from data memory. Stalls, the register file and the ALU are outside this block.

The selection logic is purely combinational. For testing it sits behind a thin wrapper that captures all stage fields in registers on the rising clock edge. Each operand's result therefore appears one cycle after its fields are presented. The two operands use identical, independent copies of the logic. The chosen source for each operand is also brought out as a 2-bit select code.

Top module: `exec_bypass_stage`

## Requirements
- R1: When an operand's source register equals the MEM-stage destination, the MEM instruction writes a register, and the register is not zero, the operand equals the MEM-stage result and its select reads 2'b01.
- R2: When an operand's source register equals the WB-stage destination, the WB instruction writes a register, the register is not zero, and R1 does not apply, the operand equals the WB write value and its select reads 2'b10.
- R3: A stage whose write-enable is low never supplies an operand, even when its destination matches.
- R4: Source register zero is never bypassed: the operand is the decode/execute value and its select reads 2'b00, whatever the destinations and enables are.
- R5: When both MEM and WB qualify for the same operand, the MEM result (the newest write) is chosen.
- R6: The select code takes only 2'b00 (decode/execute value), 2'b01 (MEM result) or 2'b10 (WB result), and never 2'b11.
- R7: Operands A and B are resolved independently, so each may pick a different source in the same cycle.
- R8: All stage fields are captured on the rising clock edge, and the outputs change only after that edge.
- R9: An active-low asynchronous reset clears every captured field, which drives both operands to zero and both selects to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_src_a | input | 5 | Source register number of operand A |
| in_src_b | input | 5 | Source register number of operand B |
| in_val_a | input | W | Decode/execute value for operand A |
| in_val_b | input | W | Decode/execute value for operand B |
| in_mem_dst | input | 5 | Destination register of the MEM-stage instruction |
| in_mem_wen | input | 1 | MEM-stage instruction writes a register |
| in_mem_res | input | W | ALU result held in the execute/memory register |
| in_wb_dst | input | 5 | Destination register of the WB-stage instruction |
| in_wb_wen | input | 1 | WB-stage instruction writes a register |
| in_wb_res | input | W | Final value being written back |
| out_op_a | output | W | Resolved operand A |
| out_op_b | output | W | Resolved operand B |
| out_sel_a | output | 2 | Source chosen for operand A |
| out_sel_b | output | 2 | Source chosen for operand B |

## Verification
The bench first targets a chain of two writes to the same register. A design with the wrong priority would hand the consumer the stale WB value instead of the MEM result. It also pairs matching destinations with a cleared write-enable; a design that ignores the enable would forward data from a store or branch. Register zero is driven with every other stage matching it, which exposes a design that forwards writes to the constant-zero register. Further vectors send A and B to different sources in the same cycle to catch crossed or shared selection, and a check taken before the clock edge catches outputs that bypass the capture registers.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    SEL_IDEX = 2'b00,
    SEL_MEM  = 2'b01,
    SEL_WB   = 2'b10
  } fwd_sel_e;

  // A producing stage qualifies when it writes a non-zero register that matches.
  function automatic logic stage_hit(
    input logic [REG_W-1:0] src,
    input logic [REG_W-1:0] dst,
    input logic             wen
  );
    return wen && (src != '0) && (src == dst);
  endfunction

  // Youngest producer first: MEM over WB over the decode/execute value.
  function automatic fwd_sel_e resolve(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SEL_MEM;
    else if (wb_hit) return SEL_WB;
    else             return SEL_IDEX;
  endfunction

endpackage

// File: rtl/bypass_pick.sv
module bypass_pick
  import fwd_pkg::*;
(
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic             mem_hit,
  output logic             wb_hit,
  output fwd_sel_e         sel
);

  always_comb begin
    mem_hit = stage_hit(src, mem_dst, mem_wen);
    wb_hit  = stage_hit(src, wb_dst, wb_wen);
    sel     = resolve(mem_hit, wb_hit);
  end

endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
  import fwd_pkg::*;
#(
  parameter int W = 32
) (
  input  fwd_sel_e       sel,
  input  logic [W-1:0]   idex_val,
  input  logic [W-1:0]   mem_val,
  input  logic [W-1:0]   wb_val,
  output logic [W-1:0]   y
);

  always_comb begin
    unique case (sel)
      SEL_MEM: y = mem_val;
      SEL_WB:  y = wb_val;
      default: y = idex_val;
    endcase
  end

endmodule

// File: rtl/bypass_core.sv
module bypass_core
  import fwd_pkg::*;
#(
  parameter int W     = 32,
  parameter int N_OPS = 2
) (
  input  logic [N_OPS-1:0][REG_W-1:0] src,
  input  logic [N_OPS-1:0][W-1:0]     idex_val,
  input  logic [REG_W-1:0]            mem_dst,
  input  logic                        mem_wen,
  input  logic [W-1:0]                mem_res,
  input  logic [REG_W-1:0]            wb_dst,
  input  logic                        wb_wen,
  input  logic [W-1:0]                wb_res,
  output logic [N_OPS-1:0][W-1:0]     op,
  output logic [N_OPS-1:0][1:0]       sel,
  output logic [N_OPS-1:0]            mem_hit,
  output logic [N_OPS-1:0]            wb_hit
);

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_sel_e sel_e;

    bypass_pick u_pick (
      .src     (src[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .mem_hit (mem_hit[g]),
      .wb_hit  (wb_hit[g]),
      .sel     (sel_e)
    );

    bypass_mux #(.W(W)) u_mux (
      .sel      (sel_e),
      .idex_val (idex_val[g]),
      .mem_val  (mem_res),
      .wb_val   (wb_res),
      .y        (op[g])
    );

    assign sel[g] = sel_e;
  end

endmodule

// File: rtl/exec_bypass_stage.sv
module exec_bypass_stage
  import fwd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [W-1:0]     in_val_a,
  input  logic [W-1:0]     in_val_b,
  input  logic [REG_W-1:0] in_mem_dst,
  input  logic             in_mem_wen,
  input  logic [W-1:0]     in_mem_res,
  input  logic [REG_W-1:0] in_wb_dst,
  input  logic             in_wb_wen,
  input  logic [W-1:0]     in_wb_res,
  output logic [W-1:0]     out_op_a,
  output logic [W-1:0]     out_op_b,
  output logic [1:0]       out_sel_a,
  output logic [1:0]       out_sel_b
);

  localparam int N_OPS = 2;

  // Captured stage fields
  logic [REG_W-1:0] r_src_a, r_src_b, r_mem_dst, r_wb_dst;
  logic [W-1:0]     r_val_a, r_val_b, r_mem_res, r_wb_res;
  logic             r_mem_wen, r_wb_wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_src_a   <= '0;
      r_src_b   <= '0;
      r_val_a   <= '0;
      r_val_b   <= '0;
      r_mem_dst <= '0;
      r_mem_wen <= 1'b0;
      r_mem_res <= '0;
      r_wb_dst  <= '0;
      r_wb_wen  <= 1'b0;
      r_wb_res  <= '0;
    end else begin
      r_src_a   <= in_src_a;
      r_src_b   <= in_src_b;
      r_val_a   <= in_val_a;
      r_val_b   <= in_val_b;
      r_mem_dst <= in_mem_dst;
      r_mem_wen <= in_mem_wen;
      r_mem_res <= in_mem_res;
      r_wb_dst  <= in_wb_dst;
      r_wb_wen  <= in_wb_wen;
      r_wb_res  <= in_wb_res;
    end
  end

  logic [N_OPS-1:0][W-1:0] op_vec;
  logic [N_OPS-1:0][1:0]   sel_vec;
  logic [N_OPS-1:0]        mem_hit_vec, wb_hit_vec;

  // Named internal events for the checker
  logic a_mem_hit, a_wb_hit, b_mem_hit, b_wb_hit;

  bypass_core #(.W(W), .N_OPS(N_OPS)) u_core (
    .src      ({r_src_b, r_src_a}),
    .idex_val ({r_val_b, r_val_a}),
    .mem_dst  (r_mem_dst),
    .mem_wen  (r_mem_wen),
    .mem_res  (r_mem_res),
    .wb_dst   (r_wb_dst),
    .wb_wen   (r_wb_wen),
    .wb_res   (r_wb_res),
    .op       (op_vec),
    .sel      (sel_vec),
    .mem_hit  (mem_hit_vec),
    .wb_hit   (wb_hit_vec)
  );

  assign out_op_a  = op_vec[0];
  assign out_op_b  = op_vec[1];
  assign out_sel_a = sel_vec[0];
  assign out_sel_b = sel_vec[1];
  assign a_mem_hit = mem_hit_vec[0];
  assign a_wb_hit  = wb_hit_vec[0];
  assign b_mem_hit = mem_hit_vec[1];
  assign b_wb_hit  = wb_hit_vec[1];

endmodule

// File: rtl/bypass_chk.sv
module bypass_chk #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] src_a,
  input logic [RW-1:0] src_b,
  input logic [W-1:0]  val_a,
  input logic [W-1:0]  val_b,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wen,
  input logic [W-1:0]  mem_res,
  input logic [RW-1:0] wb_dst,
  input logic          wb_wen,
  input logic [W-1:0]  wb_res,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          a_mem_hit,
  input logic          a_wb_hit,
  input logic          b_mem_hit,
  input logic          b_wb_hit
);

  AST_A_MEM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && src_a != 0 && src_a == mem_dst) |-> (op_a == mem_res && sel_a == 2'b01)); // R1
  AST_B_MEM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && src_b != 0 && src_b == mem_dst) |-> (op_b == mem_res && sel_b == 2'b01)); // R1
  AST_A_WB_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_mem_hit && wb_wen && src_a != 0 && src_a == wb_dst) |-> (op_a == wb_res && sel_a == 2'b10)); // R2
  AST_A_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && !wb_wen) |-> (op_a == val_a && op_b == val_b)); // R3
  AST_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == 0) |-> (op_a == val_a && sel_a == 2'b00 && !a_mem_hit && !a_wb_hit)); // R4
  AST_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b == 0) |-> (op_b == val_b && sel_b == 2'b00 && !b_mem_hit && !b_wb_hit)); // R4
  AST_B_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (b_mem_hit && b_wb_hit) |-> (op_b == mem_res)); // R5
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11 && sel_b != 2'b11)); // R6

endmodule

bind exec_bypass_stage bypass_chk #(.W(W), .RW(fwd_pkg::REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_a     (r_src_a),
  .src_b     (r_src_b),
  .val_a     (r_val_a),
  .val_b     (r_val_b),
  .mem_dst   (r_mem_dst),
  .mem_wen   (r_mem_wen),
  .mem_res   (r_mem_res),
  .wb_dst    (r_wb_dst),
  .wb_wen    (r_wb_wen),
  .wb_res    (r_wb_res),
  .op_a      (out_op_a),
  .op_b      (out_op_b),
  .sel_a     (out_sel_a),
  .sel_b     (out_sel_b),
  .a_mem_hit (a_mem_hit),
  .a_wb_hit  (a_wb_hit),
  .b_mem_hit (b_mem_hit),
  .b_wb_hit  (b_wb_hit)
);

// File: tb/sim_exec_bypass_stage.sv
`timescale 1ns/1ps
module sim_exec_bypass_stage;

  localparam int W = 32;
  localparam int NV = 12;

  typedef struct packed {
    logic [4:0] sa;
    logic [4:0] sb;
    logic [4:0] md;
    logic       mw;
    logic [4:0] wd;
    logic       ww;
    logic [1:0] ea;
    logic [1:0] eb;
  } vec_t;

  // src_a, src_b, mem_dst, mem_wen, wb_dst, wb_wen, expected sel_a, sel_b
  localparam vec_t VEC [NV] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'd0, 2'd0},
    '{5'd3,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'd1, 2'd0},
    '{5'd2,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 2'd0, 2'd2},
    '{5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'd1, 2'd1},
    '{5'd5,  5'd5,  5'd5,  1'b0, 5'd5,  1'b1, 2'd2, 2'd2},
    '{5'd5,  5'd6,  5'd5,  1'b0, 5'd6,  1'b0, 2'd0, 2'd0},
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0},
    '{5'd0,  5'd7,  5'd0,  1'b1, 5'd7,  1'b1, 2'd0, 2'd2},
    '{5'd31, 5'd31, 5'd31, 1'b1, 5'd9,  1'b1, 2'd1, 2'd1},
    '{5'd9,  5'd31, 5'd31, 1'b1, 5'd9,  1'b1, 2'd2, 2'd1},
    '{5'd31, 5'd9,  5'd31, 1'b0, 5'd31, 1'b1, 2'd2, 2'd0},
    '{5'd12, 5'd12, 5'd12, 1'b1, 5'd12, 1'b0, 2'd1, 2'd1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   in_src_a = '0, in_src_b = '0, in_mem_dst = '0, in_wb_dst = '0;
  logic [W-1:0] in_val_a = '0, in_val_b = '0, in_mem_res = '0, in_wb_res = '0;
  logic         in_mem_wen = 1'b0, in_wb_wen = 1'b0;
  logic [W-1:0] out_op_a, out_op_b;
  logic [1:0]   out_sel_a, out_sel_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exec_bypass_stage #(.W(W)) u0 (
    .clk, .rst_n, .in_src_a, .in_src_b, .in_val_a, .in_val_b,
    .in_mem_dst, .in_mem_wen, .in_mem_res, .in_wb_dst, .in_wb_wen, .in_wb_res,
    .out_op_a, .out_op_b, .out_sel_a, .out_sel_b
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick_exp(input logic [1:0] s, input logic [W-1:0] idv,
                                            input logic [W-1:0] mv, input logic [W-1:0] wv);
    if (s == 2'd1) return mv;
    if (s == 2'd2) return wv;
    return idv;
  endfunction

  task automatic drive(input vec_t v, input int i);
    in_src_a   = v.sa;
    in_src_b   = v.sb;
    in_mem_dst = v.md;
    in_mem_wen = v.mw;
    in_wb_dst  = v.wd;
    in_wb_wen  = v.ww;
    in_val_a   = 32'hA000_0000 + i;
    in_val_b   = 32'hB000_0000 + i;
    in_mem_res = 32'hCCCC_0000 + i;
    in_wb_res  = 32'hDDDD_0000 + i;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9", "op_a at reset", out_op_a, '0);
    chk("R9", "op_b at reset", out_op_b, '0);
    chk("R9", "sel_a at reset", {30'd0, out_sel_a}, 32'd0);
    chk("R9", "sel_b at reset", {30'd0, out_sel_b}, 32'd0);
    rst_n = 1'b1;

    // Vector table: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], i);
      @(posedge clk);
      @(negedge clk);
      chk("R1/R2/R5", $sformatf("vec %0d sel_a", i), {30'd0, out_sel_a}, {30'd0, VEC[i].ea});
      chk("R4/R7", $sformatf("vec %0d sel_b", i), {30'd0, out_sel_b}, {30'd0, VEC[i].eb});
      chk("R3/R6", $sformatf("vec %0d op_a", i), out_op_a,
          pick_exp(VEC[i].ea, 32'hA000_0000 + i, 32'hCCCC_0000 + i, 32'hDDDD_0000 + i));
      chk("R7", $sformatf("vec %0d op_b", i), out_op_b,
          pick_exp(VEC[i].eb, 32'hB000_0000 + i, 32'hCCCC_0000 + i, 32'hDDDD_0000 + i));
    end

    // R8: new fields do not reach outputs before the rising edge
    drive(VEC[1], 40);
    @(negedge clk);
    drive(VEC[2], 50);
    #2;
    chk("R8", "op_a before edge", out_op_a, 32'hCCCC_0028);
    chk("R8", "sel_a before edge", {30'd0, out_sel_a}, 32'd1);
    @(negedge clk);
    chk("R8", "op_b after edge", out_op_b, 32'hDDDD_0032);

    // R9: asynchronous reset mid-run clears outputs without a clock edge
    drive(VEC[3], 60);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R9", "op_a async reset", out_op_a, '0);
    chk("R9", "sel_b async reset", {30'd0, out_sel_b}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule